// File: doc/BRIEF.md
# Two-wire serial memory slave front-end

This block is the bus-facing half of a serial memory slave on an open-drain two-wire bus. A system clock that runs much faster than the bus samples the clock line and the data line. The block finds start and stop conditions and collects the eight-bit slave address. It checks that address against two device-type codes and three strap inputs, and it acknowledges on the ninth clock pulse.

After an acknowledged address, the block either collects written bytes or sends read bytes. It hands a decoded command to a back-end: memory access or protection command, the read flag, a copy of the high-voltage flag, and the write bytes. The first write byte is marked as the word address. The back-end answers with a busy level, an accept level and read data.

The data line is never driven high. The block only asserts an active-low pull-down enable, and that enable changes only while the clock line is low.

Top module: `twsm_slave`

## Requirements
- R1: After reset, and until the first start condition, the block ignores the bus. A start condition is SDA falling while SCL is high, and it may arrive at any point. It abandons the current transfer without reporting the partial byte and begins a new address byte. A stop condition is SDA rising while SCL is high. It releases SDA, and it pulses `xfer_end_o` for one cycle only if the address of that transfer was acknowledged.
- R2: The address byte is received MSB first. Bits 7:4 hold the device type: 1010 selects memory access (`cmd_prot_o`=0) and 0110 selects a protection command (`cmd_prot_o`=1). No other code is acknowledged. Bit 0 is R/W, with 1 meaning read, and it is reported on `cmd_rd_o`. A matching address pulses `cmd_valid_o` once.
- R3: Address bits 3, 2 and 1 must equal `strap_i[2]`, `strap_i[1]` and `strap_i[0]`. On a mismatch there is no acknowledge, and SDA is not driven again until the next start.
- R4: An acknowledge holds SDA low from the SCL fall after the eighth bit until the SCL fall after the ninth bit. SDA is then released.
- R5: While `be_busy_i` is high at the eighth address bit, the address is not acknowledged and the block stays silent until the next start.
- R6: While `be_accept_i` is low at the eighth address bit, the address is not acknowledged and the block stays silent until the next start.
- R7: After an acknowledged write address, every received byte pulses `wr_valid_o` with the byte on `wr_data_o`, and every such byte is acknowledged. `wr_first_o` is 1 only for the first byte after the address.
- R8: After an acknowledged read address, and after each master acknowledge (SDA low on the ninth pulse), the block pulses `rd_req_o`. It samples `rd_data_i` one clock cycle after that pulse and sends the byte MSB first. After a master no-acknowledge it drives nothing more until the next start.
- R9: The SDA enable never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull-down enable for SDA (1 drives low) |
| strap_i | input | 3 | Device select straps, floating read as 0 |
| hv_i | input | 1 | High-voltage detector flag, passed with the command |
| be_busy_i | input | 1 | Back-end internal write cycle in progress |
| be_accept_i | input | 1 | Back-end will take the command |
| rd_data_i | input | 8 | Read byte, valid one cycle after `rd_req_o` |
| cmd_valid_o | output | 1 | One-cycle pulse on a matching address |
| cmd_prot_o | output | 1 | 1 for a protection command, 0 for memory access |
| cmd_rd_o | output | 1 | R/W bit of the address |
| cmd_hv_o | output | 1 | High-voltage flag captured with the address |
| wr_valid_o | output | 1 | One-cycle pulse per received write byte |
| wr_first_o | output | 1 | Marks the word-address byte |
| wr_data_o | output | 8 | Received write byte |
| rd_req_o | output | 1 | Request for the next read byte |
| xfer_end_o | output | 1 | Stop seen after an acknowledged address |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and the codes 1010 and 0110. It runs the bus with four system clocks per quarter bit. The slave then reacts three to five clocks after each SCL fall, inside the eight-clock low phase, so the bench can observe the ordering of the SDA enable against SCL. Some address vectors mix type codes, strap patterns, busy and refusal. Others are directed transfers: writes, multi-byte reads ending in a no-acknowledge, an abort in the middle of a byte, and silence after a mismatch.

// File: rtl/twsm_pkg.sv
package twsm_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_WAIT,
        ST_RD_LOAD,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_MUTE
    } twsm_state_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } twsm_bus_t;

    // returns {hit, protection}
    function automatic logic [1:0] type_decode(input logic [3:0] nib,
                                               input logic [3:0] mem_c,
                                               input logic [3:0] prot_c);
        if (nib == mem_c)       return 2'b10;
        else if (nib == prot_c) return 2'b11;
        else                    return 2'b00;
    endfunction

endpackage

// File: rtl/twsm_sync.sv
module twsm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] pipe;
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= {pipe[STAGES-2:0], d[g]};
            end
            assign q[g] = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/twsm_cond.sv
module twsm_cond
    import twsm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_s,
    input  logic      sda_s,
    output twsm_bus_t bus
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        bus.sda      = sda_s;
        bus.scl_rise = scl_s & ~scl_q;
        bus.scl_fall = ~scl_s & scl_q;
        bus.start    = scl_s & scl_q & sda_q & ~sda_s;
        bus.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/twsm_ctrl.sv
module twsm_ctrl
    import twsm_pkg::*;
#(
    parameter logic [3:0] MEM_CODE  = 4'b1010,
    parameter logic [3:0] PROT_CODE = 4'b0110
) (
    input  logic              clk,
    input  logic              rst,
    input  twsm_bus_t         bus,
    input  logic [2:0]        strap_i,
    input  logic              hv_i,
    input  logic              be_busy_i,
    input  logic              be_accept_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              cmd_valid_o,
    output logic              cmd_prot_o,
    output logic              cmd_rd_o,
    output logic              cmd_hv_o,
    output logic              wr_valid_o,
    output logic              wr_first_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o,
    output logic              xfer_end_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    twsm_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_drive;
    logic              ack_pend;
    logic              rd;
    logic              first;
    logic              sel;
    logic              mack;

    logic [BYTE_W-1:0] rx_byte;
    logic [1:0]        type_hit;
    logic              addr_ok;

    always_comb begin
        rx_byte  = {shreg[BYTE_W-2:0], bus.sda};
        type_hit = type_decode(rx_byte[7:4], MEM_CODE, PROT_CODE);
        addr_ok  = type_hit[1] & (rx_byte[3:1] == strap_i);
        sda_oe_o = ack_drive | ((state == ST_RD_BYTE) & ~shreg[BYTE_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            shreg       <= '0;
            ack_drive   <= 1'b0;
            ack_pend    <= 1'b0;
            rd          <= 1'b0;
            first       <= 1'b0;
            sel         <= 1'b0;
            mack        <= 1'b0;
            cmd_valid_o <= 1'b0;
            cmd_prot_o  <= 1'b0;
            cmd_rd_o    <= 1'b0;
            cmd_hv_o    <= 1'b0;
            wr_valid_o  <= 1'b0;
            wr_first_o  <= 1'b0;
            wr_data_o   <= '0;
            rd_req_o    <= 1'b0;
            xfer_end_o  <= 1'b0;
        end else begin
            cmd_valid_o <= 1'b0;
            wr_valid_o  <= 1'b0;
            rd_req_o    <= 1'b0;
            xfer_end_o  <= 1'b0;
            if (bus.start) begin
                state     <= ST_ADDR;
                cnt       <= '0;
                ack_drive <= 1'b0;
                sel       <= 1'b0;
            end else if (bus.stop) begin
                state      <= ST_IDLE;
                ack_drive  <= 1'b0;
                xfer_end_o <= sel;
                sel        <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (bus.scl_rise && cnt != FULL) begin
                            shreg <= rx_byte;
                            cnt   <= cnt + CNT_W'(1);
                            if (cnt == LAST) begin
                                rd          <= bus.sda;
                                ack_pend    <= addr_ok & ~be_busy_i & be_accept_i;
                                cmd_valid_o <= addr_ok;
                                if (addr_ok) begin
                                    cmd_prot_o <= type_hit[0];
                                    cmd_rd_o   <= bus.sda;
                                    cmd_hv_o   <= hv_i;
                                end
                            end
                        end
                        if (bus.scl_fall && cnt == FULL) begin
                            if (ack_pend) begin
                                ack_drive <= 1'b1;
                                sel       <= 1'b1;
                                state     <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_MUTE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (bus.scl_fall) begin
                            ack_drive <= 1'b0;
                            cnt       <= '0;
                            first     <= 1'b1;
                            if (rd) begin
                                rd_req_o <= 1'b1;
                                state    <= ST_RD_WAIT;
                            end else begin
                                state <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (bus.scl_rise && cnt != FULL) begin
                            shreg <= rx_byte;
                            cnt   <= cnt + CNT_W'(1);
                            if (cnt == LAST) begin
                                wr_valid_o <= 1'b1;
                                wr_data_o  <= rx_byte;
                                wr_first_o <= first;
                            end
                        end
                        if (bus.scl_fall && cnt == FULL) begin
                            ack_drive <= 1'b1;
                            first     <= 1'b0;
                            state     <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (bus.scl_fall) begin
                            ack_drive <= 1'b0;
                            cnt       <= '0;
                            state     <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_WAIT: state <= ST_RD_LOAD;
                    ST_RD_LOAD: begin
                        shreg <= rd_data_i;
                        cnt   <= '0;
                        state <= ST_RD_BYTE;
                    end
                    ST_RD_BYTE: begin
                        if (bus.scl_rise && cnt != FULL) cnt <= cnt + CNT_W'(1);
                        if (bus.scl_fall && cnt != '0) begin
                            if (cnt == FULL) state <= ST_RD_ACK;
                            else shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RD_ACK: begin
                        if (bus.scl_rise) mack <= ~bus.sda;
                        if (bus.scl_fall) begin
                            if (mack) begin
                                rd_req_o <= 1'b1;
                                state    <= ST_RD_WAIT;
                            end else begin
                                state <= ST_MUTE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/twsm_slave.sv
module twsm_slave
    import twsm_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] MEM_CODE    = 4'b1010,
    parameter logic [3:0] PROT_CODE   = 4'b0110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic              hv_i,
    input  logic              be_busy_i,
    input  logic              be_accept_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              cmd_valid_o,
    output logic              cmd_prot_o,
    output logic              cmd_rd_o,
    output logic              cmd_hv_o,
    output logic              wr_valid_o,
    output logic              wr_first_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o,
    output logic              xfer_end_o
);
    logic      scl_s, sda_s;
    twsm_bus_t bus;

    twsm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   ({scl_s, sda_s})
    );

    twsm_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .bus   (bus)
    );

    twsm_ctrl #(.MEM_CODE(MEM_CODE), .PROT_CODE(PROT_CODE)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .bus         (bus),
        .strap_i     (strap_i),
        .hv_i        (hv_i),
        .be_busy_i   (be_busy_i),
        .be_accept_i (be_accept_i),
        .rd_data_i   (rd_data_i),
        .sda_oe_o    (sda_oe_o),
        .cmd_valid_o (cmd_valid_o),
        .cmd_prot_o  (cmd_prot_o),
        .cmd_rd_o    (cmd_rd_o),
        .cmd_hv_o    (cmd_hv_o),
        .wr_valid_o  (wr_valid_o),
        .wr_first_o  (wr_first_o),
        .wr_data_o   (wr_data_o),
        .rd_req_o    (rd_req_o),
        .xfer_end_o  (xfer_end_o)
    );
endmodule

// File: rtl/twsm_slave_chk.sv
module twsm_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe_o,
    input logic cmd_valid_o,
    input logic wr_valid_o,
    input logic rd_req_o,
    input logic be_busy_i,
    input logic be_accept_i
);
    logic busy_q, accept_q, muted_busy, muted_reject;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q       <= 1'b0;
            accept_q     <= 1'b1;
            muted_busy   <= 1'b0;
            muted_reject <= 1'b0;
        end else begin
            busy_q   <= be_busy_i;
            accept_q <= be_accept_i;
            if (start_det) begin
                muted_busy   <= 1'b0;
                muted_reject <= 1'b0;
            end else if (cmd_valid_o) begin
                if (busy_q)    muted_busy   <= 1'b1;
                if (!accept_q) muted_reject <= 1'b1;
            end
        end
    end

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst) stop_det |=> !sda_oe_o); // R1
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst) muted_busy |-> !sda_oe_o); // R5
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst) muted_reject |-> !sda_oe_o); // R6
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst) $onehot0({cmd_valid_o, wr_valid_o, rd_req_o})); // R7
    AST_WR_LINE_FREE: assert property (@(posedge clk) disable iff (rst) wr_valid_o |-> !sda_oe_o); // R7
    AST_RDREQ_SCL_LOW: assert property (@(posedge clk) disable iff (rst) rd_req_o |-> !scl_s); // R8
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) (sda_oe_o != $past(sda_oe_o)) |-> !scl_s); // R9
endmodule

bind twsm_slave twsm_slave_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_s       (scl_s),
    .start_det   (bus.start),
    .stop_det    (bus.stop),
    .sda_oe_o    (sda_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .wr_valid_o  (wr_valid_o),
    .rd_req_o    (rd_req_o),
    .be_busy_i   (be_busy_i),
    .be_accept_i (be_accept_i)
);

// File: tb/test_twsm_slave.sv
module test_twsm_slave;
    localparam int Q = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, scl_m, sda_m, hv, busy, accept;
    logic [2:0] strap;
    logic [7:0] rd_base;
    logic       sda_oe, cmd_valid, cmd_prot, cmd_rd, cmd_hv;
    logic       wr_valid, wr_first, rd_req, xfer_end;
    logic [7:0] wr_data, rd_data;
    logic       sda_line;

    int cmd_cnt, wr_cnt, rd_cnt, end_cnt;
    logic [8:0] wr_log [64];
    logic last_prot, last_rd;

    int n_chk = 0, n_bad = 0, hold_viol = 0;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = rd_base + 8'(rd_cnt);

    twsm_slave i_twsm_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_i(strap), .hv_i(hv), .be_busy_i(busy), .be_accept_i(accept),
        .rd_data_i(rd_data), .cmd_valid_o(cmd_valid), .cmd_prot_o(cmd_prot),
        .cmd_rd_o(cmd_rd), .cmd_hv_o(cmd_hv), .wr_valid_o(wr_valid),
        .wr_first_o(wr_first), .wr_data_o(wr_data), .rd_req_o(rd_req),
        .xfer_end_o(xfer_end)
    );

    always @(posedge clk) begin
        if (rst) begin
            cmd_cnt <= 0; wr_cnt <= 0; rd_cnt <= 0; end_cnt <= 0;
            last_prot <= 1'b0; last_rd <= 1'b0;
        end else begin
            if (cmd_valid) begin
                cmd_cnt <= cmd_cnt + 1; last_prot <= cmd_prot; last_rd <= cmd_rd;
            end
            if (wr_valid) begin
                wr_log[wr_cnt % 64] <= {wr_first, wr_data};
                wr_cnt <= wr_cnt + 1;
            end
            if (rd_req)   rd_cnt  <= rd_cnt + 1;
            if (xfer_end) end_cnt <= end_cnt + 1;
        end
    end

    // {addr[7:0], strap[2:0], busy, accept, expected ack}
    localparam logic [13:0] VEC [10] = '{
        {8'hA0, 3'b000, 1'b0, 1'b1, 1'b1},
        {8'h60, 3'b000, 1'b0, 1'b1, 1'b1},
        {8'hAA, 3'b101, 1'b0, 1'b1, 1'b1},
        {8'hAA, 3'b100, 1'b0, 1'b1, 1'b0},
        {8'hAB, 3'b011, 1'b0, 1'b1, 1'b0},
        {8'h50, 3'b000, 1'b0, 1'b1, 1'b0},
        {8'hA0, 3'b000, 1'b1, 1'b1, 1'b0},
        {8'hA0, 3'b000, 1'b0, 1'b0, 1'b0},
        {8'h6E, 3'b111, 1'b0, 1'b1, 1'b1},
        {8'hE0, 3'b000, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic q_wait;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic drv, output logic seen);
        logic a;
        sda_m = drv;
        q_wait();
        scl_m = 1'b1;
        a = sda_oe;
        q_wait();
        seen = sda_line;
        q_wait();
        if (sda_oe !== a) hold_viol++;
        scl_m = 1'b0;
        q_wait();
    endtask

    task automatic bus_start;
        sda_m = 1'b1; q_wait();
        scl_m = 1'b1; q_wait();
        sda_m = 1'b0; q_wait();
        scl_m = 1'b0; q_wait();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; q_wait();
        scl_m = 1'b1; q_wait();
        sda_m = 1'b1; q_wait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(v[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            v[i] = s;
        end
        bit_xfer(nack, s);
    endtask

    initial begin
        logic       ack, s, allhi;
        logic [7:0] v;
        int         w0, e0, r0;
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; strap = 3'b000; hv = 1'b0;
        busy = 1'b0; accept = 1'b1; rd_base = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset sda_oe", 32'(sda_oe), 0);
        check("R1 reset cmd_valid", 32'(cmd_valid), 0);

        // bytes clocked before any start are ignored
        scl_m = 1'b0; q_wait();
        send_byte(8'hA0, ack);
        check("R1 no ack before first start", 32'(ack), 0);
        check("R1 no command before first start", 32'(cmd_cnt), 0);
        bus_stop();

        // address vectors
        for (int k = 0; k < 10; k++) begin
            strap  = VEC[k][5:3];
            busy   = VEC[k][2];
            accept = VEC[k][1];
            bus_start();
            send_byte(VEC[k][13:6], ack);
            bus_stop();
            check($sformatf("R2 R3 R4 R5 R6 vector %0d ack", k), 32'(ack), 32'(VEC[k][0]));
            if (VEC[k][0]) begin
                check($sformatf("R2 vector %0d kind", k), 32'(last_prot), 32'(VEC[k][13:10] == 4'h6));
                check($sformatf("R2 vector %0d rw", k), 32'(last_rd), 32'(VEC[k][6]));
            end
        end
        busy = 1'b0; accept = 1'b1;

        // write of three bytes
        strap = 3'b010;
        w0 = wr_cnt; e0 = end_cnt;
        bus_start();
        send_byte(8'hA4, ack);
        check("R4 write address ack", 32'(ack), 1);
        check("R4 SDA released after ninth pulse", 32'(sda_oe), 0);
        send_byte(8'h37, ack); check("R7 ack byte 0", 32'(ack), 1);
        send_byte(8'hC2, ack); check("R7 ack byte 1", 32'(ack), 1);
        send_byte(8'h5D, ack); check("R7 ack byte 2", 32'(ack), 1);
        bus_stop();
        q_wait();
        check("R7 write byte count", 32'(wr_cnt - w0), 3);
        check("R7 byte 0 first+data", 32'(wr_log[w0 % 64]), 32'({1'b1, 8'h37}));
        check("R7 byte 1 first+data", 32'(wr_log[(w0 + 1) % 64]), 32'({1'b0, 8'hC2}));
        check("R7 byte 2 first+data", 32'(wr_log[(w0 + 2) % 64]), 32'({1'b0, 8'h5D}));
        check("R1 transfer end pulse", 32'(end_cnt - e0), 1);

        // sequential read ending in no-acknowledge
        rd_base = 8'h40;
        r0 = rd_cnt;
        bus_start();
        send_byte(8'hA5, ack);
        check("R8 read address ack", 32'(ack), 1);
        read_byte(1'b0, v); check("R8 read byte 0", 32'(v), 32'(8'h40 + 8'(r0 + 1)));
        read_byte(1'b0, v); check("R8 read byte 1", 32'(v), 32'(8'h40 + 8'(r0 + 2)));
        read_byte(1'b1, v); check("R8 read byte 2", 32'(v), 32'(8'h40 + 8'(r0 + 3)));
        allhi = 1'b1;
        for (int i = 0; i < 9; i++) begin
            bit_xfer(1'b1, s);
            allhi = allhi & s;
        end
        check("R8 silent after master no-ack", 32'(allhi), 1);
        check("R8 request count", 32'(rd_cnt - r0), 3);
        bus_stop();

        // start in the middle of a byte aborts it
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hA4, ack);
        for (int i = 0; i < 4; i++) bit_xfer(i[0], s);
        bus_start();
        send_byte(8'hA4, ack);
        check("R1 ack after restart", 32'(ack), 1);
        send_byte(8'h99, ack);
        bus_stop();
        q_wait();
        check("R1 partial byte dropped", 32'(wr_cnt - w0), 1);
        check("R1 first byte after restart", 32'(wr_log[w0 % 64]), 32'({1'b1, 8'h99}));

        // strap mismatch keeps the slave silent for the whole transfer
        strap = 3'b001;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hA4, ack);
        check("R3 mismatch no ack", 32'(ack), 0);
        send_byte(8'h00, ack);
        check("R3 silent on following byte", 32'(ack), 0);
        bus_stop();
        check("R3 no byte reported", 32'(wr_cnt - w0), 0);

        check("R9 SDA stable while SCL high", 32'(hold_viol), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule